// File: doc/BRIEF.md
# Four-Phase Handshake Clock-Domain Crossing

This block moves one multi-bit word at a time between two clock domains that have no fixed relation to each other. It does not encode the word as a Gray-coded counter. A single token passes back and forth on two one-bit flags, a request and an acknowledge. This makes it fit for arbitrary values: configuration words, commands, or samples that repeat or jump. The cost is throughput, because each word needs a full return-to-zero round trip through two synchronizers.

On the source side a producer offers a word with a valid/ready handshake. The block stores the word in a holding register and raises the request. The request reaches the destination through a two-flop synchronizer. There the word is sampled, presented for exactly one destination cycle with a valid strobe, and answered by raising the acknowledge. The acknowledge travels back through its own synchronizer. The source then drops the request, and the destination drops the acknowledge. Only when the source sees the synchronized acknowledge low again does it take the next word. The holding register can change only while the source owns the token.

Top module: `hs_cdc_bridge`

## Requirements
- R1: After each domain's synchronous reset, src_ready is 1 and dst_valid is 0.
- R2: A word is accepted on a src_clk edge where src_valid and src_ready are both 1. In the source cycle after that edge, src_ready is 0.
- R3: From acceptance until the token returns, the holding register does not change. src_valid and src_data offered while src_ready is 0 are ignored, and those words never appear at the destination.
- R4: The source clears its request only after it has seen the synchronized acknowledge high.
- R5: src_ready rises again only when the request is low and the synchronized acknowledge is low. So a new word is never accepted before the previous word has been presented at the destination.
- R6: Each transferred word is presented on dst_data together with a dst_valid strobe that lasts exactly one dst_clk cycle.
- R7: Every accepted word is delivered exactly once and in order. This holds whether the destination clock is faster than, slower than, or equal to the source clock.
- R8: Values are carried as is, with no monotonic assumption. All-zero, all-one and back-to-back identical words each produce their own strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source domain clock |
| src_rst | input | 1 | Source domain synchronous reset, active high |
| src_valid | input | 1 | Producer offers a word |
| src_data | input | DATA_W | Offered word |
| src_ready | output | 1 | Block can take a word this cycle |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst | input | 1 | Destination domain synchronous reset, active high |
| dst_valid | output | 1 | One-cycle strobe: dst_data holds a new word |
| dst_data | output | DATA_W | Delivered word |

## Verification
The stream is run with the destination clock slower, faster and equal in rate to the source clock. These runs separate a correct handshake from one that depends on a particular clock ratio: at a fast destination a lost edge shows up as a duplicate, and at a slow one as a missing word. While the block is busy, random junk words are held on src_data with src_valid high. A design that loads outside token ownership would then deliver a word that is not expected. Directed words of all zeros, all ones and identical pairs check that a repeated value still gives one strobe per transfer and is not merged.

// File: rtl/hs_cdc_pkg.sv
`timescale 1ns/1ps
package hs_cdc_pkg;

  typedef enum logic [1:0] {
    SRC_IDLE  = 2'd0,
    SRC_OWNED = 2'd1,
    SRC_DRAIN = 2'd2
  } src_state_e;

  // source may load a new word only with both flags low
  function automatic logic src_may_load(input logic req_q, input logic ack_seen);
    return !req_q && !ack_seen;
  endfunction

  // destination sees a fresh request it has not answered yet
  function automatic logic dst_new_word(input logic req_seen, input logic ack_q);
    return req_seen && !ack_q;
  endfunction

  // destination releases the token back once the request has dropped
  function automatic logic dst_release(input logic req_seen, input logic ack_q);
    return !req_seen && ack_q;
  endfunction

endpackage

// File: rtl/hs_bit_sync.sv
`timescale 1ns/1ps
module hs_bit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic q_sync
);
  localparam int N = (STAGES < 2) ? 2 : STAGES;

  logic [N-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q[0] <= 1'b0;
    else     chain_q[0] <= d_async;
  end

  for (genvar g = 1; g < N; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain_q[g] <= 1'b0;
      else     chain_q[g] <= chain_q[g-1];
    end
  end

  assign q_sync = chain_q[N-1];
endmodule

// File: rtl/hs_src_side.sv
`timescale 1ns/1ps
module hs_src_side
  import hs_cdc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              req_o,
  input  logic              ack_async,
  output logic [DATA_W-1:0] word_o,
  output logic              ack_seen_o,
  output logic              take_o
);
  src_state_e        state_q, state_d;
  logic              req_q, req_d;
  logic [DATA_W-1:0] word_q;
  logic              ack_seen;

  hs_bit_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk    (clk),
    .rst    (rst),
    .d_async(ack_async),
    .q_sync (ack_seen)
  );

  assign in_ready = (state_q == SRC_IDLE) && src_may_load(req_q, ack_seen);
  assign take_o   = in_valid && in_ready;

  always_comb begin
    state_d = state_q;
    req_d   = req_q;
    unique case (state_q)
      SRC_IDLE:  if (take_o)    begin state_d = SRC_OWNED; req_d = 1'b1; end
      SRC_OWNED: if (ack_seen)  begin state_d = SRC_DRAIN; req_d = 1'b0; end
      SRC_DRAIN: if (!ack_seen) begin state_d = SRC_IDLE; end
      default:   begin state_d = SRC_IDLE; req_d = 1'b0; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SRC_IDLE;
      req_q   <= 1'b0;
      word_q  <= '0;
    end else begin
      state_q <= state_d;
      req_q   <= req_d;
      if (take_o) word_q <= in_data;
    end
  end

  assign req_o      = req_q;
  assign word_o     = word_q;
  assign ack_seen_o = ack_seen;
endmodule

// File: rtl/hs_dst_side.sv
`timescale 1ns/1ps
module hs_dst_side
  import hs_cdc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_async,
  input  logic [DATA_W-1:0] word_async,
  output logic              ack_o,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              req_seen_o,
  output logic              capture_o
);
  logic              ack_q;
  logic              valid_q;
  logic [DATA_W-1:0] data_q;
  logic              req_seen;

  hs_bit_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk    (clk),
    .rst    (rst),
    .d_async(req_async),
    .q_sync (req_seen)
  );

  assign capture_o = dst_new_word(req_seen, ack_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_q   <= 1'b0;
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= capture_o;
      if (capture_o) begin
        data_q <= word_async;
        ack_q  <= 1'b1;
      end else if (dst_release(req_seen, ack_q)) begin
        ack_q  <= 1'b0;
      end
    end
  end

  assign ack_o      = ack_q;
  assign out_valid  = valid_q;
  assign out_data   = data_q;
  assign req_seen_o = req_seen;
endmodule

// File: rtl/hs_cdc_bridge.sv
`timescale 1ns/1ps
module hs_cdc_bridge #(
  parameter int DATA_W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              src_clk,
  input  logic              src_rst,
  input  logic              src_valid,
  input  logic [DATA_W-1:0] src_data,
  output logic              src_ready,
  input  logic              dst_clk,
  input  logic              dst_rst,
  output logic              dst_valid,
  output logic [DATA_W-1:0] dst_data
);
  logic              req_flag;
  logic              ack_flag;
  logic [DATA_W-1:0] hold_word;
  logic              ack_seen_src;
  logic              req_seen_dst;
  logic              take_evt;
  logic              capture_evt;

  hs_src_side #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_src (
    .clk       (src_clk),
    .rst       (src_rst),
    .in_valid  (src_valid),
    .in_data   (src_data),
    .in_ready  (src_ready),
    .req_o     (req_flag),
    .ack_async (ack_flag),
    .word_o    (hold_word),
    .ack_seen_o(ack_seen_src),
    .take_o    (take_evt)
  );

  hs_dst_side #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_dst (
    .clk       (dst_clk),
    .rst       (dst_rst),
    .req_async (req_flag),
    .word_async(hold_word),
    .ack_o     (ack_flag),
    .out_valid (dst_valid),
    .out_data  (dst_data),
    .req_seen_o(req_seen_dst),
    .capture_o (capture_evt)
  );
endmodule

// File: rtl/hs_cdc_checks.sv
`timescale 1ns/1ps
module hs_cdc_checks #(
  parameter int DATA_W = 16
) (
  input logic              src_clk,
  input logic              src_rst,
  input logic              src_ready,
  input logic              take_evt,
  input logic              req_flag,
  input logic              ack_seen_src,
  input logic [DATA_W-1:0] hold_word,
  input logic              dst_clk,
  input logic              dst_rst,
  input logic              dst_valid,
  input logic              ack_flag,
  input logic              req_seen_dst,
  input logic              capture_evt
);
  // R2
  accept_closes_ready_chk: assert property (@(posedge src_clk) disable iff (src_rst)
    take_evt |=> (req_flag && !src_ready));

  // R3
  hold_stable_chk: assert property (@(posedge src_clk) disable iff (src_rst)
    req_flag |=> (!req_flag || $stable(hold_word)));

  // R4
  req_drop_after_ack_chk: assert property (@(posedge src_clk) disable iff (src_rst)
    $fell(req_flag) |-> $past(ack_seen_src));

  // R5
  ready_needs_idle_flags_chk: assert property (@(posedge src_clk) disable iff (src_rst)
    src_ready |-> (!req_flag && !ack_seen_src));

  // R6
  valid_single_cycle_chk: assert property (@(posedge dst_clk) disable iff (dst_rst)
    dst_valid |=> !dst_valid);

  // R6
  valid_follows_capture_chk: assert property (@(posedge dst_clk) disable iff (dst_rst)
    capture_evt |=> (dst_valid && ack_flag));

  // R7
  ack_drop_needs_req_low_chk: assert property (@(posedge dst_clk) disable iff (dst_rst)
    $fell(ack_flag) |-> $past(!req_seen_dst));
endmodule

bind hs_cdc_bridge hs_cdc_checks #(.DATA_W(DATA_W)) u_chk (
  .src_clk     (src_clk),
  .src_rst     (src_rst),
  .src_ready   (src_ready),
  .take_evt    (take_evt),
  .req_flag    (req_flag),
  .ack_seen_src(ack_seen_src),
  .hold_word   (hold_word),
  .dst_clk     (dst_clk),
  .dst_rst     (dst_rst),
  .dst_valid   (dst_valid),
  .ack_flag    (ack_flag),
  .req_seen_dst(req_seen_dst),
  .capture_evt (capture_evt)
);

// File: tb/hs_cdc_bridge_tb.sv
`timescale 1ns/1ps
module hs_cdc_bridge_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 16;
  localparam int WORDS_PER_PHASE = 40;
  localparam int MAXW = 512;

  logic              src_clk = 1'b0, dst_clk = 1'b0;
  logic              src_rst = 1'b1, dst_rst = 1'b1;
  logic              src_valid = 1'b0;
  logic [DATA_W-1:0] src_data = '0;
  logic              src_ready, dst_valid;
  logic [DATA_W-1:0] dst_data;
  int                dst_half = CLK_PERIOD / 2;

  int total = 0, bad = 0;
  int acc_cnt = 0, del_cnt = 0;
  logic [DATA_W-1:0] exp_q [MAXW];
  logic prev_valid = 1'b0;
  bit   done = 1'b0;

  hs_cdc_bridge #(.DATA_W(DATA_W), .SYNC_STAGES(2)) u_dut (
    .src_clk(src_clk), .src_rst(src_rst), .src_valid(src_valid),
    .src_data(src_data), .src_ready(src_ready),
    .dst_clk(dst_clk), .dst_rst(dst_rst),
    .dst_valid(dst_valid), .dst_data(dst_data)
  );

  always #(CLK_PERIOD/2) src_clk = ~src_clk;
  always #(dst_half) dst_clk = ~dst_clk;

  // scrambled, non-monotonic word; directed values at chosen indices (R8)
  function automatic logic [DATA_W-1:0] word_for(input int idx);
    logic [31:0] x;
    if (idx % 40 == 3) return '0;
    if (idx % 40 == 4) return '1;
    if (idx % 40 == 6) return word_for(idx - 1);
    x = (idx * 32'd40503) ^ (idx << 7) ^ 32'h5a3c;
    return x[DATA_W-1:0] ^ x[31:32-DATA_W];
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // destination monitor (R6, R7, R8)
  always @(negedge dst_clk) begin
    if (!dst_rst) begin
      if (dst_valid) begin
        check(!prev_valid, "R6 strobe longer than one cycle", 1, 0);
        if (del_cnt < acc_cnt)
          check(dst_data == exp_q[del_cnt], "R7/R8 word order/value",
                int'(dst_data), int'(exp_q[del_cnt]));
        else
          check(1'b0, "R3/R7 extra word delivered", int'(dst_data), -1);
        del_cnt++;
      end
      prev_valid = dst_valid;
    end
  end

  task automatic send_word(input logic [DATA_W-1:0] w, input bit junk);
    @(negedge src_clk);
    src_valid = 1'b1;
    while (!src_ready) begin
      if (junk) src_data = DATA_W'($urandom);  // R3: ignored while busy
      @(negedge src_clk);
    end
    src_data = w;
    // R5: all earlier words presented before ready returned
    check(del_cnt == acc_cnt, "R5 ready before previous delivery", del_cnt, acc_cnt);
    exp_q[acc_cnt] = w;
    acc_cnt++;
    @(negedge src_clk);
    check(src_ready == 1'b0, "R2 ready after accept", int'(src_ready), 0);
    src_valid = 1'b0;
    src_data  = DATA_W'($urandom);
    repeat ($urandom_range(0, 3)) @(negedge src_clk);
  endtask

  task automatic drain();
    int guard = 0;
    while (del_cnt != acc_cnt && guard < 2000) begin
      @(negedge src_clk);
      guard++;
    end
    check(del_cnt == acc_cnt, "R7 words lost", del_cnt, acc_cnt);
  endtask

  task automatic run_phase(input int half, input int base);
    dst_half = half;
    repeat (4) @(negedge src_clk);
    for (int i = 0; i < WORDS_PER_PHASE; i++)
      send_word(word_for(base + i), (i % 3) == 1);
    drain();
    // R3: junk never leaks after the stream has drained
    repeat (30) @(negedge src_clk);
    check(del_cnt == acc_cnt, "R3 junk word delivered", del_cnt, acc_cnt);
  endtask

  initial begin
    void'($urandom(32'd12345));
    repeat (5) @(negedge src_clk);
    src_rst = 1'b0;
    dst_rst = 1'b0;
    @(negedge src_clk);
    // R1
    check(src_ready == 1'b1, "R1 src_ready after reset", int'(src_ready), 1);
    check(dst_valid == 1'b0, "R1 dst_valid after reset", int'(dst_valid), 0);
    run_phase(17, 0);     // R7 slower destination
    run_phase(2, 40);     // R7 faster destination
    run_phase(5, 80);     // R7 equal rate
    check(acc_cnt == 3 * WORDS_PER_PHASE, "R7 total accepted", acc_cnt, 3 * WORDS_PER_PHASE);
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", del_cnt, acc_cnt);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule